// File: doc/BRIEF.md
# Two-Register Cached Data Stack

This block is the operand stack of a stack-machine core. The two uppermost cells are kept in flip-flops, the top cell (TOS) and the cell beneath it (NOS), so the ALU sees both operands after only a register clock-to-output delay and never waits on a RAM access. Everything deeper lives in a small RAM with one write port and one read port. The write port always addresses the slot that NOS would be spilled into on a push. The read port always addresses the slot that would refill NOS on a pop.

Each cycle the sequencer presents a two-bit stack-effect code and the value TOS must take, which an external multiplexer has already selected (ALU result, literal, the old NOS and so on). The block moves NOS to or from the RAM as the code requires. A double pop removes two cells, and the read port can only supply one of them per cycle. The block therefore spends one extra cycle, with its RAM addresses one slot lower, to fetch the second cell. It raises a busy flag during that cycle so that the sequencer can stall.

Top module: `pair_cached_stack`

## Requirements
- R1: While reset is high and in the first cycle after it is released, TOS and NOS read zero and busy is low.
- R2: The stack-effect code is 0 = hold, 1 = push, 2 = pop, 3 = double pop. When busy is low, TOS takes the value on the new-TOS input at the next clock edge, whatever the code.
- R3: A hold leaves NOS and the spilled cells unchanged.
- R4: A push moves the old TOS into NOS and spills the old NOS into the RAM as the newest saved cell.
- R5: A pop refills NOS with the newest saved cell and removes that cell from the RAM, so cells come back in last-in first-out order.
- R6: A double pop removes two saved cells. Once it completes, NOS holds the cell that was second newest and the next pop returns the third newest.
- R7: Busy is high for exactly the one cycle that follows an accepted double pop. In that cycle the code and new-TOS inputs are ignored and TOS keeps its value.
- R8: The saved-cell pointer wraps modulo the RAM depth. After more pushes than the depth, the oldest cells are overwritten and the newest DEPTH cells still come back in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Stack-effect code |
| tos_new_i | input | WIDTH | Value TOS takes on an accepted operation |
| tos_o | output | WIDTH | Registered top of stack |
| nos_o | output | WIDTH | Registered next on stack |
| busy_o | output | 1 | High during the extra cycle of a double pop |

## Verification
The bench builds the stack with DEPTH = 8 and WIDTH = 16. The shallow RAM lets a short sequence of ten pushes followed by ten pops drive the pointer past both ends of its range, so overwriting of the oldest cells and last-in first-out order across the wrap can be observed. The narrow width keeps distinct marker values easy to read. Double pops are issued with deliberately conflicting code and TOS inputs during the busy cycle, so any leak of those inputs shows up on TOS or NOS.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_DPOP = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        NOS_KEEP = 2'd0,
        NOS_TOS  = 2'd1,
        NOS_RAM  = 2'd2
    } nos_src_e;

    typedef enum logic [1:0] {
        PTR_STAY = 2'd0,
        PTR_UP   = 2'd1,
        PTR_DOWN = 2'd2
    } ptr_step_e;

    typedef struct packed {
        logic      tos_ld;
        nos_src_e  nos_src;
        logic      wr_en;
        ptr_step_e step;
    } stk_ctl_t;

    function automatic stk_ctl_t decode_op(input stk_op_e op, input logic busy);
        stk_ctl_t c;
        c = '{tos_ld: 1'b0, nos_src: NOS_KEEP, wr_en: 1'b0, step: PTR_STAY};
        if (busy) begin
            c.nos_src = NOS_RAM;
            c.step    = PTR_DOWN;
        end else begin
            c.tos_ld = 1'b1;
            unique case (op)
                OP_HOLD: ;
                OP_PUSH: begin
                    c.nos_src = NOS_TOS;
                    c.wr_en   = 1'b1;
                    c.step    = PTR_UP;
                end
                OP_POP, OP_DPOP: begin
                    c.nos_src = NOS_RAM;
                    c.step    = PTR_DOWN;
                end
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/pcs_spill_ram.sv
module pcs_spill_ram #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_e       op,
    output stk_ctl_t      ctl,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          busy
);

    logic [AW-1:0] ptr_q;
    logic          busy_q;

    assign ctl     = decode_op(op, busy_q);
    assign wr_addr = ptr_q;
    assign rd_addr = ptr_q - AW'(1);
    assign busy    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            unique case (ctl.step)
                PTR_UP:   ptr_q <= ptr_q + AW'(1);
                PTR_DOWN: ptr_q <= ptr_q - AW'(1);
                default:  ptr_q <= ptr_q;
            endcase
            busy_q <= !busy_q && (op == OP_DPOP);
        end
    end

    a_r7_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !busy_q);

    a_r6_dpop_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && op == OP_DPOP) |=> busy_q);

    a_r8_push_wraps_up: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_en |=> ptr_q == $past(ptr_q) + AW'(1));

    a_r5_pop_steps_down: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && op == OP_POP) |=> ptr_q == $past(ptr_q) - AW'(1));

endmodule

// File: rtl/pair_cached_stack.sv
module pair_cached_stack
    import pcs_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] tos_new_i,
    output logic [WIDTH-1:0] tos_o,
    output logic [WIDTH-1:0] nos_o,
    output logic             busy_o
);

    stk_ctl_t         ctl;
    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_addr;
    logic [WIDTH-1:0] rd_data;
    logic [WIDTH-1:0] tos_q;
    logic [WIDTH-1:0] nos_q;
    logic             busy;

    pcs_seq #(.DEPTH(DEPTH)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .op      (stk_op_e'(op_i)),
        .ctl     (ctl),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .busy    (busy)
    );

    pcs_spill_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) ram_i (
        .clk     (clk),
        .wr_en   (ctl.wr_en),
        .wr_addr (wr_addr),
        .wr_data (nos_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            nos_q <= '0;
        end else begin
            if (ctl.tos_ld) begin
                tos_q <= tos_new_i;
            end
            unique case (ctl.nos_src)
                NOS_TOS: nos_q <= tos_q;
                NOS_RAM: nos_q <= rd_data;
                default: nos_q <= nos_q;
            endcase
        end
    end

    assign tos_o  = tos_q;
    assign nos_o  = nos_q;
    assign busy_o = busy;

    a_r2_tos_loads: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> tos_o == $past(tos_new_i));

    a_r3_hold_keeps_nos: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && op_i == 2'd0) |=> $stable(nos_o));

    a_r4_push_moves_tos: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && op_i == 2'd1) |=> nos_o == $past(tos_o));

    a_r7_tos_frozen: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(tos_o));

endmodule

// File: tb/pair_cached_stack_tb_top.sv
module pair_cached_stack_tb_top;

    localparam int D = 8;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_i = 2'd0;
    logic [W-1:0] tos_new_i = '0;
    logic [W-1:0] tos_o;
    logic [W-1:0] nos_o;
    logic         busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_tos, m_nos;
    logic [W-1:0] m_ram [D];
    logic [2:0]   m_ptr;
    logic         m_busy;

    always #10 clk = ~clk;

    pair_cached_stack #(.DEPTH(D), .WIDTH(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .tos_new_i (tos_new_i),
        .tos_o     (tos_o),
        .nos_o     (nos_o),
        .busy_o    (busy_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "tos", tos_o, m_tos);
        chk(tag, "nos", nos_o, m_nos);
        chk(tag, "busy", W'(busy_o), W'(m_busy));
    endtask

    task automatic model(input logic [1:0] op, input logic [W-1:0] v);
        if (m_busy) begin
            m_ptr  = m_ptr - 3'd1;
            m_nos  = m_ram[m_ptr];
            m_busy = 1'b0;
        end else begin
            case (op)
                2'd1: begin
                    m_ram[m_ptr] = m_nos;
                    m_ptr = m_ptr + 3'd1;
                    m_nos = m_tos;
                end
                2'd2, 2'd3: begin
                    m_ptr  = m_ptr - 3'd1;
                    m_nos  = m_ram[m_ptr];
                    m_busy = (op == 2'd3);
                end
                default: ;
            endcase
            m_tos = v;
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [W-1:0] v, input string tag);
        @(negedge clk);
        op_i = op;
        tos_new_i = v;
        @(posedge clk);
        #1;
        model(op, v);
        chk_all(tag);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        m_tos = '0; m_nos = '0; m_ptr = '0; m_busy = 1'b0;
        for (int i = 0; i < D; i++) m_ram[i] = '0;
        chk_all("R1");
        @(negedge clk);
        rst = 1'b0;
        op_i = 2'd0;
        tos_new_i = '0;
        @(posedge clk);
        #1;
        chk_all("R1");
    endtask

    // R2, R3: hold loads TOS, keeps NOS
    task automatic t_hold();
        step(2'd0, 16'h1111, "R2");
        step(2'd0, 16'h2222, "R3");
    endtask

    // R4: pushes
    task automatic t_push();
        step(2'd1, 16'hA001, "R4");
        step(2'd1, 16'hA002, "R4");
        step(2'd1, 16'hA003, "R4");
        step(2'd1, 16'hA004, "R4");
        step(2'd1, 16'hA005, "R4");
    endtask

    // R5: pop returns newest spilled cell
    task automatic t_pop();
        step(2'd2, 16'hB001, "R5");
        step(2'd0, 16'hB002, "R5");
    endtask

    // R6, R7: double pop with conflicting inputs in busy cycle
    task automatic t_dpop();
        step(2'd1, 16'hC001, "R6");
        step(2'd1, 16'hC002, "R6");
        step(2'd3, 16'hC003, "R7");
        step(2'd1, 16'hDEAD, "R7");
        step(2'd2, 16'hC004, "R6");
        step(2'd3, 16'hC005, "R6");
        step(2'd3, 16'hBEEF, "R7");
        step(2'd0, 16'hC006, "R7");
    endtask

    // R8: pointer wraps past the RAM depth
    task automatic t_wrap();
        for (int i = 0; i < D + 2; i++) step(2'd1, W'(16'hE000 + i), "R8");
        for (int i = 0; i < D + 2; i++) step(2'd2, W'(16'hF000 + i), "R8");
    endtask

    initial begin
        t_reset();
        t_hold();
        t_push();
        t_pop();
        t_dpop();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule